// File: doc/BRIEF.md
# Bit-Plane AND-Popcount Dot-Product Engine

This engine forms the dot product of a small window of unsigned activations with one convolution kernel, without a multiplier. Operands are held as bit-planes. One array of rows holds the activations, with one row per bit position and one column per window element. One row array per filter holds the weights in the same layout. Each cycle, one activation row and one weight row are ANDed bit by bit. The set bits are counted, the count is shifted left by the sum of the two bit positions, and the shifted count is added to a running sum.

One processing element serves several filters of the same input channel. After a start pulse it works through the filters in ascending order and emits one result per filter, each flagged by a one-cycle done pulse that carries the filter index. A per-filter skip mask marks pruned kernels. Such a kernel costs no row-pair cycles: it reports zero one cycle after the sequencer reaches it, so downstream logic still sees every filter index. The planes and the skip mask are supplied by surrounding logic and must stay stable while the engine is busy.

Top module: `bitplane_dot_engine`

## Requirements
- R1: After reset, busy, done and result are all 0.
- R2: For a kernel not marked in skip_mask, result equals the sum over all elements of activation × weight, with both operands unsigned. Bit b of element e sits at act_planes[b*N_ELEM+e]. For filter f, bit b of element e sits at wgt_planes[(f*W_BITS+b)*N_ELEM+e].
- R3: Each accepted start produces exactly N_FILT done pulses, with done_filt taking the values 0, 1, …, N_FILT-1 in that order.
- R4: A kernel that is not skipped spends exactly A_BITS×W_BITS cycles. The first result appears A_BITS×W_BITS cycles after the clock edge that samples start, and each later non-skipped result appears that many cycles after the previous done.
- R5: A kernel with skip_mask[f]=1 reports result 0 with done_filt=f, one cycle after the sequencer reaches it.
- R6: A start pulse that arrives while busy is high has no effect on the sequence or the results.
- R7: busy goes high in the cycle after start is accepted. It stays high through every done except the last, and is low in the cycle that carries the done for filter N_FILT-1.
- R8: With every activation and weight at its maximum value, the result is N_ELEM×(2^A_BITS−1)×(2^W_BITS−1) with no overflow (196 with the default parameters).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass over all filters (accepted only when idle) |
| skip_mask | input | N_FILT | 1 marks a pruned kernel |
| act_planes | input | A_BITS*N_ELEM | Activation bit-plane rows |
| wgt_planes | input | N_FILT*W_BITS*N_ELEM | Weight bit-plane rows, filter-major |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse: result is valid |
| done_filt | output | clog2(N_FILT) | Filter index of the current result |
| result | output | clog2(MAX+1) | Dot product (0 for a skipped kernel) |

## Verification
The hardest situation to create from the ports is a start pulse that lands in the middle of a pass. A design that wrongly accepted it would restart the filter sequence, and the scoreboard would show this only through extra or out-of-order results. The driver therefore raises start a few cycles into a pass whose skip mask mixes pruned and live kernels. It then waits long enough for any spurious results to surface. Per-pass latency is measured against the cost of one cycle per skipped kernel and A_BITS×W_BITS cycles per live kernel, and an all-maximum pass exercises the top of the accumulator range.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bpd_state_e;
endpackage

// File: rtl/bpd_row_mux.sv
module bpd_row_mux #(
    parameter int N_ROWS = 3,
    parameter int ROW_W  = 4,
    parameter int SEL_W  = 2
) (
    input  logic [N_ROWS*ROW_W-1:0] planes,
    input  logic [SEL_W-1:0]        sel,
    output logic [ROW_W-1:0]        row
);
    localparam int SLOTS = 1 << SEL_W;

    logic [ROW_W-1:0] rows [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < N_ROWS) begin : g_real
            assign rows[g] = planes[g*ROW_W +: ROW_W];
        end else begin : g_pad
            assign rows[g] = '0;
        end
    end

    assign row = rows[sel];
endmodule

// File: rtl/bpd_popcount.sv
module bpd_popcount #(
    parameter int WIDTH = 4,
    parameter int CNT_W = 3
) (
    input  logic [WIDTH-1:0] bits,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] part [WIDTH+1];

    assign part[0] = '0;
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        assign part[g+1] = part[g] + CNT_W'(bits[g]);
    end

    assign count = part[WIDTH];
endmodule

// File: rtl/bpd_shift_term.sv
module bpd_shift_term #(
    parameter int CNT_W = 3,
    parameter int SH_W  = 3,
    parameter int OUT_W = 8
) (
    input  logic [CNT_W-1:0] count,
    input  logic [SH_W-1:0]  shift,
    output logic [OUT_W-1:0] term
);
    assign term = OUT_W'(count) << shift;
endmodule

// File: rtl/bitplane_dot_engine.sv
module bitplane_dot_engine #(
    parameter int N_ELEM = 4,
    parameter int A_BITS = 3,
    parameter int W_BITS = 3,
    parameter int N_FILT = 4,
    localparam int MAX_SUM = N_ELEM * ((1 << A_BITS) - 1) * ((1 << W_BITS) - 1),
    localparam int ACC_W   = $clog2(MAX_SUM + 1),
    localparam int FILT_W  = (N_FILT > 1) ? $clog2(N_FILT) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic [N_FILT-1:0]                skip_mask,
    input  logic [A_BITS*N_ELEM-1:0]         act_planes,
    input  logic [N_FILT*W_BITS*N_ELEM-1:0]  wgt_planes,
    output logic                             busy,
    output logic                             done,
    output logic [FILT_W-1:0]                done_filt,
    output logic [ACC_W-1:0]                 result
);
    import bpd_pkg::*;

    localparam int AI_W  = (A_BITS > 1) ? $clog2(A_BITS) : 1;
    localparam int WI_W  = (W_BITS > 1) ? $clog2(W_BITS) : 1;
    localparam int WR_W  = (N_FILT * W_BITS > 1) ? $clog2(N_FILT * W_BITS) : 1;
    localparam int CNT_W = $clog2(N_ELEM + 1);
    localparam int SH_W  = (A_BITS + W_BITS > 2) ? $clog2(A_BITS + W_BITS - 1) : 1;

    typedef struct packed {
        bpd_state_e        st;
        logic              busy;
        logic [FILT_W-1:0] filt;
        logic [AI_W-1:0]   ai;
        logic [WI_W-1:0]   wi;
        logic [ACC_W-1:0]  acc;
        logic              done;
        logic [FILT_W-1:0] rfilt;
        logic [ACC_W-1:0]  result;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [N_ELEM-1:0] act_row, wgt_row;
    logic [WR_W-1:0]   wsel;
    logic [CNT_W-1:0]  pop;
    logic [SH_W-1:0]   shamt;
    logic [ACC_W-1:0]  term;

    assign wsel  = WR_W'(seq_q.filt) * WR_W'(W_BITS) + WR_W'(seq_q.wi);
    assign shamt = SH_W'(seq_q.ai) + SH_W'(seq_q.wi);

    bpd_row_mux #(.N_ROWS(A_BITS), .ROW_W(N_ELEM), .SEL_W(AI_W)) i_act_mux (
        .planes(act_planes), .sel(seq_q.ai), .row(act_row)
    );

    bpd_row_mux #(.N_ROWS(N_FILT*W_BITS), .ROW_W(N_ELEM), .SEL_W(WR_W)) i_wgt_mux (
        .planes(wgt_planes), .sel(wsel), .row(wgt_row)
    );

    bpd_popcount #(.WIDTH(N_ELEM), .CNT_W(CNT_W)) i_pop (
        .bits(act_row & wgt_row), .count(pop)
    );

    bpd_shift_term #(.CNT_W(CNT_W), .SH_W(SH_W), .OUT_W(ACC_W)) i_shift (
        .count(pop), .shift(shamt), .term(term)
    );

    always_comb begin
        logic             last_ai, last_wi, last_f;
        logic [ACC_W-1:0] sum;
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        last_ai    = (seq_q.ai == AI_W'(A_BITS - 1));
        last_wi    = (seq_q.wi == WI_W'(W_BITS - 1));
        last_f     = (seq_q.filt == FILT_W'(N_FILT - 1));
        sum        = seq_q.acc + term;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st   = ST_RUN;
                    seq_d.busy = 1'b1;
                    seq_d.filt = '0;
                    seq_d.ai   = '0;
                    seq_d.wi   = '0;
                    seq_d.acc  = '0;
                end
            end
            ST_RUN: begin
                if (skip_mask[seq_q.filt] || (last_ai && last_wi)) begin
                    seq_d.done   = 1'b1;
                    seq_d.rfilt  = seq_q.filt;
                    seq_d.result = skip_mask[seq_q.filt] ? '0 : sum;
                    seq_d.acc    = '0;
                    seq_d.ai     = '0;
                    seq_d.wi     = '0;
                    if (last_f) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.busy = 1'b0;
                    end else begin
                        seq_d.filt = seq_q.filt + 1'b1;
                    end
                end else begin
                    seq_d.acc = sum;
                    if (last_ai) begin
                        seq_d.ai = '0;
                        seq_d.wi = seq_q.wi + 1'b1;
                    end else begin
                        seq_d.ai = seq_q.ai + 1'b1;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = seq_q.busy;
    assign done      = seq_q.done;
    assign done_filt = seq_q.rfilt;
    assign result    = seq_q.result;
endmodule

// File: rtl/bpd_checker.sv
module bpd_checker #(
    parameter int N_ELEM = 4,
    parameter int A_BITS = 3,
    parameter int W_BITS = 3,
    parameter int N_FILT = 4,
    localparam int MAX_SUM = N_ELEM * ((1 << A_BITS) - 1) * ((1 << W_BITS) - 1),
    localparam int ACC_W   = $clog2(MAX_SUM + 1),
    localparam int FILT_W  = (N_FILT > 1) ? $clog2(N_FILT) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [N_FILT-1:0] skip_mask,
    input logic              busy,
    input logic              done,
    input logic [FILT_W-1:0] done_filt,
    input logic [ACC_W-1:0]  result
);
    localparam logic [15:0] PAIRS = 16'(A_BITS * W_BITS);

    logic [FILT_W-1:0] exp_filt_q;
    logic [15:0]       gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_filt_q <= '0;
            gap_q      <= '0;
        end else if (start && !busy) begin
            exp_filt_q <= '0;
            gap_q      <= '0;
        end else if (done) begin
            exp_filt_q <= exp_filt_q + 1'b1;
            gap_q      <= 16'd1;
        end else if (gap_q != 16'hFFFF) begin
            gap_q <= gap_q + 16'd1;
        end
    end

    a_r3_filter_order: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> done_filt == exp_filt_q);

    a_r4_pair_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !skip_mask[done_filt]) |-> gap_q == PAIRS);

    a_r5_skip_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && skip_mask[done_filt]) |-> (result == '0 && gap_q == 16'd1));

    a_r6_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r7_idle_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_filt == FILT_W'(N_FILT - 1)) |-> !busy);

    a_r8_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> 32'(result) <= MAX_SUM);
endmodule

bind bitplane_dot_engine bpd_checker #(
    .N_ELEM(N_ELEM), .A_BITS(A_BITS), .W_BITS(W_BITS), .N_FILT(N_FILT)
) i_bpd_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .skip_mask(skip_mask),
    .busy(busy), .done(done), .done_filt(done_filt), .result(result)
);

// File: tb/test_bitplane_dot_engine.sv
module test_bitplane_dot_engine;
    localparam int NE = 4, AB = 3, WB = 3, NF = 4;
    localparam int MAXS = NE * ((1 << AB) - 1) * ((1 << WB) - 1);
    localparam int RW = $clog2(MAXS + 1);
    localparam int FW = $clog2(NF);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NF-1:0]     skip_mask = '0;
    logic [AB*NE-1:0]  act_planes = '0;
    logic [NF*WB*NE-1:0] wgt_planes = '0;
    logic              busy, done;
    logic [FW-1:0]     done_filt;
    logic [RW-1:0]     result;

    bitplane_dot_engine #(.N_ELEM(NE), .A_BITS(AB), .W_BITS(WB), .N_FILT(NF)) i_bitplane_dot_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .skip_mask(skip_mask),
        .act_planes(act_planes), .wgt_planes(wgt_planes),
        .busy(busy), .done(done), .done_filt(done_filt), .result(result)
    );

    typedef struct {
        int    filt;
        int    val;
        string req;
    } exp_t;

    exp_t sb[$];
    int   errors = 0;
    int   checks = 0;
    bit   finished = 0;
    int   act_v [NE];
    int   wt_v  [NF][NE];

    task automatic check(input bit ok, input string req, input string what,
                         input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    // Monitor: pops one expected item per result pulse
    always @(negedge clk) begin
        if (rst_n && done && !finished) begin
            if (sb.size() == 0) begin
                check(1'b0, "R3", "unexpected result for filter", int'(done_filt), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(int'(done_filt) == e.filt, "R3", "filter index", int'(done_filt), e.filt);
                check(int'(result) == e.val, e.req, "dot product", int'(result), e.val);
            end
        end
    end

    // Driver: packs planes, pushes expected items, runs one pass
    task automatic run_job(input logic [NF-1:0] skp, input bit restart, input string req);
        int total = 0;
        int cyc;
        for (int e = 0; e < NE; e++) begin
            for (int b = 0; b < AB; b++) act_planes[b*NE+e] = act_v[e][b];
            for (int f = 0; f < NF; f++)
                for (int b = 0; b < WB; b++) wgt_planes[(f*WB+b)*NE+e] = wt_v[f][e][b];
        end
        skip_mask = skp;
        for (int f = 0; f < NF; f++) begin
            exp_t it;
            int s = 0;
            for (int e = 0; e < NE; e++) s += act_v[e] * wt_v[f][e];
            it.filt = f;
            it.val  = skp[f] ? 0 : s;
            it.req  = skp[f] ? "R5" : req;
            sb.push_back(it);
            total += skp[f] ? 1 : AB * WB;
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 0;
        check(busy == 1'b1, "R7", "busy after start", int'(busy), 1);
        while (!(done && int'(done_filt) == NF - 1) && cyc < 5000) begin
            start = (restart && cyc == 2);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(cyc == total, "R4", "cycles to last result", cyc, total);
        check(busy == 1'b0, "R7", "busy at last result", int'(busy), 0);
        repeat (restart ? AB * WB * NF + 4 : 3) @(negedge clk);
        check(sb.size() == 0, restart ? "R6" : "R3", "results left pending", sb.size(), 0);
        check(busy == 1'b0, restart ? "R6" : "R7", "idle after pass", int'(busy), 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        check(done == 1'b0, "R1", "done after reset", int'(done), 0);
        check(result == '0, "R1", "result after reset", int'(result), 0);

        // R2: ascending pattern
        for (int e = 0; e < NE; e++) begin
            act_v[e] = e + 1;
            for (int f = 0; f < NF; f++) wt_v[f][e] = (f * 3 + e * 2 + 1) % 8;
        end
        run_job('0, 1'b0, "R2");

        // R2: pseudo-random patterns
        for (int k = 0; k < 3; k++) begin
            for (int e = 0; e < NE; e++) begin
                act_v[e] = $urandom_range(0, 7);
                for (int f = 0; f < NF; f++) wt_v[f][e] = $urandom_range(0, 7);
            end
            run_job('0, 1'b0, "R2");
        end

        // R8: every operand at its maximum
        for (int e = 0; e < NE; e++) begin
            act_v[e] = 7;
            for (int f = 0; f < NF; f++) wt_v[f][e] = 7;
        end
        run_job('0, 1'b0, "R8");

        // R5: alternate kernels pruned, live ones at maximum
        run_job(4'b0101, 1'b0, "R2");

        // R5: every kernel pruned
        run_job(4'b1111, 1'b0, "R2");

        // R6: extra start mid-pass, mixed mask
        for (int e = 0; e < NE; e++) begin
            act_v[e] = 7 - e;
            for (int f = 0; f < NF; f++) wt_v[f][e] = (e + f + 2) % 8;
        end
        run_job(4'b0010, 1'b1, "R2");

        // R2: all-zero activations
        for (int e = 0; e < NE; e++) act_v[e] = 0;
        run_job(4'b1000, 1'b0, "R2");

        finished = 1;
        summary();
        $finish;
    end
endmodule